// File: doc/BRIEF.md
# Clock-Gated Pseudo-Random Pattern Generator

This block produces a 16-bit pseudo-random pattern from a linear feedback shift register whose clock is switched off whenever the block is idle. The register's clock comes from a clock gate. The gate holds a run request in a latch while the input clock is low and ANDs it with the clock. While the run request is low, the register sees no edges at all. Its outputs then stay frozen, and every gate they feed sees no activity.

Software or a neighbouring controller seeds the register through a load strobe and starts it by raising the run request. While running, the block advances one step on every clock. The whole 16-bit state is available in parallel, and its most significant bit is also presented as a serial output bit. A pause of any length leaves the state untouched, and the next run step continues the same sequence exactly. Reset is synchronous and active low. Reset forces the gate open so that the register can take its reset value.

Top module: `lfsr_gated_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the state is set to 16'h0001 whatever the run request, and `ser_o` reads 0.
- R2: With `run_en` high and `load` low, each rising `clk` edge moves the state one place toward the MSB (state[i] takes state[i-1]). The new bit 0 is the XOR of bits 15, 13, 12 and 10 of the old state.
- R3: `ser_o` always equals bit 15 of `state_o`.
- R4: With `run_en` low, `state_o` and `ser_o` stay unchanged across any number of clock cycles.
- R5: After a pause, the first run step continues from the held state exactly as if the pause had not occurred.
- R6: With `run_en` and `load` both high, the next rising edge places a non-zero `seed` in the state. The load takes priority over the shift.
- R7: A load of an all-zero seed puts 16'h0001 in the state, so the state is never zero.
- R8: A load strobe while `run_en` is low has no effect. The state is held, and the next run step shifts the held value and not the seed.
- R9: The run request is latched while `clk` is low. A pulse on `run_en` that starts and ends within a high phase of `clk` causes no step.
- R10: Started from any non-zero state, the sequence returns to that state after exactly 65535 steps and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run request; the register is clocked only while it is high |
| load | input | 1 | Seed load strobe, acted on only while running |
| seed | input | 16 | Seed value to load |
| state_o | output | 16 | Current register state |
| ser_o | output | 1 | Serial output, the state MSB |

## Verification
Any corruption of the internal state appears at once on `state_o`, because the register drives the port directly. A wrong tap, a lost bit or a step taken during a pause therefore shows up at the very next compare against the bench's reference sequence. A gate that leaks edges while idle shows within one clock of the pause starting, as a state change. A latch that is transparent in the wrong phase shows as a step after a run pulse confined to a high phase. A feedback error that keeps single steps plausible but shortens the cycle shows up only in the full-period run, after at most 65535 cycles.

// File: rtl/lfsr_gate_pkg.sv
// Package: shared defaults and the per-edge action type for the
// clock-gated pattern generator. Assumes nothing beyond 1800-2017.
package lfsr_gate_pkg;

    localparam int unsigned DEF_WIDTH = 16;
    // Taps at bit positions 15, 13, 12, 10 (polynomial x^16+x^14+x^13+x^11+1).
    localparam logic [DEF_WIDTH-1:0] DEF_TAPS      = 16'hB400;
    localparam logic [DEF_WIDTH-1:0] DEF_RESET_VAL = 16'h0001;

    typedef enum logic [1:0] {
        ACT_RESET = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_STEP  = 2'd2
    } lfsr_act_e;

endpackage

// File: rtl/lfsr_clock_gate.sv
`timescale 1ns/1ps
// Module: lfsr_clock_gate
// Behavioural clock gate. The enable is captured by a latch that is
// transparent while clk is low and opaque while clk is high, and the
// latched value is ANDed with clk. Assumes en settles during the low phase.
module lfsr_clock_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    logic en_lat;

    // Purpose: hold the enable steady across the high phase of clk.
    always_latch begin
        if (!clk) begin
            en_lat <= en;
        end
    end

    // Purpose: pass clock edges only while the latched enable is high.
    assign gclk = clk & en_lat;

endmodule

// File: rtl/lfsr_seed_fix.sv
`timescale 1ns/1ps
// Module: lfsr_seed_fix
// Replaces the lock-up value (all zeros) by a safe substitute so the
// register can never be loaded into a state it cannot leave.
module lfsr_seed_fix #(
    parameter int unsigned          WIDTH    = 16,
    parameter logic [WIDTH-1:0]     SUBST    = 16'h0001
) (
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] seed_o
);

    // Purpose: pick the substitute when every seed bit is zero.
    always_comb begin
        seed_o = (seed_i == '0) ? SUBST : seed_i;
    end

endmodule

// File: rtl/lfsr_core.sv
`timescale 1ns/1ps
// Module: lfsr_core
// Shift register with XOR feedback, clocked by the gated clock. Each edge
// applies one action: reset, load or step. Assumes the caller only lets
// edges through when an action is wanted.
module lfsr_core
    import lfsr_gate_pkg::*;
#(
    parameter int unsigned      WIDTH     = 16,
    parameter logic [WIDTH-1:0] TAPS      = 16'hB400,
    parameter logic [WIDTH-1:0] RESET_VAL = 16'h0001
) (
    input  logic             gclk,
    input  logic             rst_n,
    input  lfsr_act_e        act,
    input  logic [WIDTH-1:0] seed_safe,
    output logic [WIDTH-1:0] state_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] tapped;
    logic             fb_bit;
    logic [WIDTH-1:0] state_next;

    // Purpose: select the tapped bits, one generate branch per position.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_tap
        if (TAPS[gi]) begin : g_on
            assign tapped[gi] = state_q[gi];
        end else begin : g_off
            assign tapped[gi] = 1'b0;
        end
    end

    // Purpose: form the feedback bit and the shifted next state.
    always_comb begin
        fb_bit     = ^tapped;
        state_next = {state_q[MSB-1:0], fb_bit};
    end

    // Purpose: update the register on each gated edge.
    always_ff @(posedge gclk) begin
        case (act)
            ACT_RESET: state_q <= RESET_VAL;
            ACT_LOAD:  state_q <= seed_safe;
            default:   state_q <= state_next;
        endcase
    end

    assign state_o = state_q;

    AST_NEVER_ZERO: assert property (@(posedge gclk) disable iff (!rst_n)
        state_q != '0);  // R7

endmodule

// File: rtl/lfsr_gated_pattern_gen.sv
`timescale 1ns/1ps
// Module: lfsr_gated_pattern_gen (top)
// Pattern generator whose register clock is gated by the run request.
// Reset forces the gate open so the synchronous reset can complete.
// Assumes run_en, load and seed change only while clk is low or are
// otherwise stable by the end of the low phase.
module lfsr_gated_pattern_gen
    import lfsr_gate_pkg::*;
#(
    parameter int unsigned          WIDTH     = DEF_WIDTH,
    parameter logic [WIDTH-1:0]     TAPS      = DEF_TAPS,
    parameter logic [WIDTH-1:0]     RESET_VAL = DEF_RESET_VAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state_o,
    output logic             ser_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic             gate_en;
    logic             gclk;
    logic [WIDTH-1:0] seed_safe;
    lfsr_act_e        act;

    // Purpose: open the gate for running or for reset.
    assign gate_en = run_en | ~rst_n;

    // Purpose: choose the action the next gated edge performs.
    always_comb begin
        if (!rst_n)    act = ACT_RESET;
        else if (load) act = ACT_LOAD;
        else           act = ACT_STEP;
    end

    lfsr_clock_gate u_gate (
        .clk  (clk),
        .en   (gate_en),
        .gclk (gclk)
    );

    lfsr_seed_fix #(.WIDTH(WIDTH), .SUBST(RESET_VAL)) u_seed (
        .seed_i (seed),
        .seed_o (seed_safe)
    );

    lfsr_core #(.WIDTH(WIDTH), .TAPS(TAPS), .RESET_VAL(RESET_VAL)) u_core (
        .gclk      (gclk),
        .rst_n     (rst_n),
        .act       (act),
        .seed_safe (seed_safe),
        .state_o   (state_o)
    );

    // Purpose: present the MSB as the serial stream.
    assign ser_o = state_o[MSB];

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(state_o));  // R4
    AST_SHIFT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !load) |=> state_o[MSB:1] == $past(state_o[MSB-1:0]));  // R2
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && load && seed != '0) |=> state_o == $past(seed));  // R6
    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && load && seed == '0) |=> state_o == RESET_VAL);  // R7

endmodule

// File: tb/sim_lfsr_gated_pattern_gen.sv
`timescale 1ns/1ps
module sim_lfsr_gated_pattern_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] seed = 16'h0000;
    logic [15:0] state_o;
    logic        ser_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] ref_st;

    always #4 clk = ~clk;

    lfsr_gated_pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .load(load),
        .seed(seed), .state_o(state_o), .ser_o(ser_o)
    );

    // Vector: {load, run_en, seed}
    localparam int NV = 16;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b1, 16'h0000}, {1'b0, 1'b1, 16'h0000},
        {1'b0, 1'b0, 16'h0000}, {1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b0, 16'h1234}, {1'b0, 1'b1, 16'h0000},
        {1'b1, 1'b1, 16'hBEEF}, {1'b0, 1'b1, 16'h0000},
        {1'b1, 1'b1, 16'h0000}, {1'b0, 1'b1, 16'h0000},
        {1'b1, 1'b1, 16'h8000}, {1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b1, 16'h0000}, {1'b1, 1'b1, 16'hFFFF},
        {1'b0, 1'b1, 16'h0000}, {1'b0, 1'b0, 16'h0000}
    };

    function automatic logic [15:0] step_of(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic string tag_of(input logic ld, input logic rn, input logic [15:0] sd);
        if (!rn && ld)       return "R8";
        if (!rn)             return "R4";
        if (ld && sd == '0)  return "R7";
        if (ld)              return "R6";
        return "R2/R5";
    endfunction

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] start;
        logic        early;
        logic        stable_ok;
        // R1: reset state
        repeat (3) cyc();
        check("R1", state_o, 16'h0001);
        check("R1", {15'd0, ser_o}, 16'h0000);
        rst_n = 1'b1;
        ref_st = 16'h0001;
        cyc();
        check("R4", state_o, ref_st);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            load   = VEC[i][17];
            run_en = VEC[i][16];
            seed   = VEC[i][15:0];
            cyc();
            if (VEC[i][16]) begin
                if (VEC[i][17]) ref_st = (VEC[i][15:0] == '0) ? 16'h0001 : VEC[i][15:0];
                else            ref_st = step_of(ref_st);
            end
            check(tag_of(VEC[i][17], VEC[i][16], VEC[i][15:0]), state_o, ref_st);
            check("R3", {15'd0, ser_o}, {15'd0, state_o[15]});
        end
        load = 1'b0;
        run_en = 1'b0;

        // R4: long pause, state held every cycle
        stable_ok = 1'b1;
        for (int i = 0; i < 50; i++) begin
            cyc();
            if (state_o !== ref_st) stable_ok = 1'b0;
        end
        check("R4", {15'd0, stable_ok}, 16'h0001);

        // R5: resume exact sequence
        run_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            cyc();
            ref_st = step_of(ref_st);
        end
        check("R5", state_o, ref_st);
        run_en = 1'b0;
        cyc();
        check("R4", state_o, ref_st);

        // R9: run pulse confined to a high phase causes no step
        @(posedge clk);
        #1 run_en = 1'b1;
        #2 run_en = 1'b0;
        #1;
        cyc();
        check("R9", state_o, ref_st);

        // R10: full period from a fresh seed
        load = 1'b1; run_en = 1'b1; seed = 16'hACE1;
        cyc();
        load = 1'b0;
        start = state_o;
        check("R6", start, 16'hACE1);
        early = 1'b0;
        for (int i = 1; i < 65535; i++) begin
            cyc();
            if (state_o === start) early = 1'b1;
        end
        check("R10", {15'd0, early}, 16'h0000);
        cyc();
        check("R10", state_o, start);

        // R1: reset while idle forces the register back
        run_en = 1'b0;
        rst_n = 1'b0;
        cyc();
        check("R1", state_o, 16'h0001);
        rst_n = 1'b1;
        cyc();
        finish_run();
    end

endmodule